// File: doc/BRIEF.md
# Multiprocessor Occupancy Solver

This block works out how many thread blocks can be resident on one streaming multiprocessor at the same time, given what a single block consumes and what the multiprocessor provides. It takes the thread count of a block, the registers each thread needs and the shared memory each block needs. It also takes four per-multiprocessor ceilings: threads, registers, shared-memory bytes and blocks. From these it derives the resident block count, the active warp count, the warp capacity, and an occupancy fraction.

Each resource that a block consumes gives its own block count. The register count and the shared-memory count come from floor division. When a block uses none of a resource, that count falls back to the hardware block ceiling. The smallest of the three counts wins. One restoring divider, which yields one quotient bit per clock, is shared by all three quotients: the two resource counts and the occupancy fraction. A caller loads the operands, pulses a start strobe and waits for a one-cycle done strobe. The outputs stay put until the next done strobe.

Top module: `sm_occupancy_calc`

## Requirements
- R1: Warps per block equals the block thread count divided by 32, rounded up. `max_warps_o` equals the per-multiprocessor thread ceiling divided by 32, rounded down.
- R2: When both register figures are nonzero, the register-bound block count is floor(SM registers / (registers per thread × threads per block)).
- R3: When shared memory per block is nonzero, the shared-memory-bound block count is floor(SM shared bytes / shared bytes per block).
- R4: When registers per thread or threads per block is zero, the register bound equals the block ceiling. When shared memory per block is zero, the shared-memory bound equals the block ceiling.
- R5: `blocks_o` is the smallest of the block ceiling, the register bound and the shared-memory bound. `act_warps_o` is `blocks_o` × warps per block.
- R6: `occ_o` is unsigned fixed point with 15 fraction bits and equals floor(active × 32768 / max warps). Whenever active ≥ max warps it is clamped to 0x8000, which means exactly 1.0.
- R7: When max warps is zero (a thread ceiling below 32), `err_o` is 1 and `occ_o` is 0. Otherwise `err_o` is 0.
- R8: The inputs are sampled in the cycle that `start_i` is high while the block is idle. `done_o` is high for exactly one cycle per accepted start, and the result ports change only in that cycle.
- R9: A `start_i` pulse that arrives while a computation is in progress is ignored. It neither alters that computation's result nor produces a second `done_o`.
- R10: After reset all result ports are zero and `done_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start strobe |
| thr_per_blk_i | input | TPB_W | Threads in one block |
| reg_per_thr_i | input | RPT_W | Registers used by each thread |
| smem_per_blk_i | input | SMB_W | Shared-memory bytes used by one block |
| sm_max_thr_i | input | MT_W | Thread ceiling of the multiprocessor |
| sm_max_reg_i | input | MR_W | Register ceiling of the multiprocessor |
| sm_max_smem_i | input | MS_W | Shared-memory byte ceiling of the multiprocessor |
| sm_max_blk_i | input | MB_W | Resident block ceiling of the multiprocessor |
| blocks_o | output | MB_W | Resident block count |
| act_warps_o | output | MB_W+TPB_W-4 | Active warp count |
| max_warps_o | output | MT_W-5 | Warp capacity |
| occ_o | output | 16 | Occupancy, 1.15 fixed point |
| err_o | output | 1 | Warp capacity is zero |
| done_o | output | 1 | One-cycle result strobe |

## Verification
The directed operand sets are chosen so that each input can be seen winning the minimum on its own: one set is bound by registers, one by shared memory and one by the block ceiling. Further sets zero out the register product, the shared-memory use, or both, to show that the guard substitutes the ceiling rather than dividing. Thread counts of 0, 33 and exact multiples of 32 separate round-up from truncation. Occupancy cases land at exactly 1.0, strictly above it (clamped), fractional values, and a zero or sub-32 thread ceiling for the error path. Seeded random operands then spread the three limits across their ranges, and an overlapping start checks that the in-flight result is kept.

// File: rtl/occ_pkg.sv
package occ_pkg;
  typedef enum logic [3:0] {
    ST_IDLE, ST_REG, ST_REG_W, ST_SMEM, ST_SMEM_W, ST_MIN, ST_OCC, ST_OCC_W, ST_FIN
  } occ_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/occ_divider.sv
module occ_divider #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go_i,
  input  logic [DW-1:0] num_i,
  input  logic [DW-1:0] den_i,
  output logic [DW-1:0] quo_o,
  output logic          done_o
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] rem_q, quo_q;
  logic [CW-1:0] cnt_q;
  logic [DW:0]   shifted, trial;

  assign shifted = {rem_q, quo_q[DW-1]};
  assign trial   = shifted - {1'b0, den_i};
  assign quo_o   = quo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_q  <= '0;
      quo_q  <= '0;
      cnt_q  <= '0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (go_i) begin
        rem_q <= '0;
        quo_q <= num_i;
        cnt_q <= CW'(DW);
      end else if (cnt_q != '0) begin
        if (!trial[DW]) begin
          rem_q <= trial[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b1};
        end else begin
          rem_q <= shifted[DW-1:0];
          quo_q <= {quo_q[DW-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) done_o <= 1'b1;
      end
    end
  end

  // R8
  div_done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
endmodule

// File: rtl/occ_limit_min.sv
module occ_limit_min #(
  parameter int MB_W = 6,
  parameter int DW   = 32
) (
  input  logic [MB_W-1:0] ceil_i,
  input  logic [DW-1:0]   lim_a_i,
  input  logic [DW-1:0]   lim_b_i,
  output logic [MB_W-1:0] min_o
);
  logic [DW-1:0] m;
  always_comb begin
    m = DW'(ceil_i);
    if (lim_a_i < m) m = lim_a_i;
    if (lim_b_i < m) m = lim_b_i;
    min_o = m[MB_W-1:0];
  end
endmodule

// File: rtl/sm_occupancy_calc.sv
module sm_occupancy_calc
  import occ_pkg::*;
#(
  parameter int TPB_W    = 11,
  parameter int RPT_W    = 8,
  parameter int SMB_W    = 18,
  parameter int MT_W     = 12,
  parameter int MR_W     = 17,
  parameter int MS_W     = 18,
  parameter int MB_W     = 6,
  parameter int OCC_FRAC = 15
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        start_i,
  input  logic [TPB_W-1:0]            thr_per_blk_i,
  input  logic [RPT_W-1:0]            reg_per_thr_i,
  input  logic [SMB_W-1:0]            smem_per_blk_i,
  input  logic [MT_W-1:0]             sm_max_thr_i,
  input  logic [MR_W-1:0]             sm_max_reg_i,
  input  logic [MS_W-1:0]             sm_max_smem_i,
  input  logic [MB_W-1:0]             sm_max_blk_i,
  output logic [MB_W-1:0]             blocks_o,
  output logic [MB_W+TPB_W-5:0]       act_warps_o,
  output logic [MT_W-6:0]             max_warps_o,
  output logic [OCC_FRAC:0]           occ_o,
  output logic                        err_o,
  output logic                        done_o
);
  localparam int WPB_W  = TPB_W - 4;
  localparam int MW_W   = MT_W - 5;
  localparam int PROD_W = RPT_W + TPB_W;
  localparam int ACT_W  = MB_W + WPB_W;
  localparam int OW     = OCC_FRAC + 1;
  localparam int DW     = imax(imax(MR_W, MS_W), imax(PROD_W, ACT_W + OCC_FRAC + 1));
  localparam int DW2    = 2 * DW;
  localparam logic [OW-1:0] ONE = OW'(1) << OCC_FRAC;

  occ_state_t st;
  logic [TPB_W-1:0] c_tpb;
  logic [RPT_W-1:0] c_rpt;
  logic [SMB_W-1:0] c_smb;
  logic [MT_W-1:0]  c_mt;
  logic [MR_W-1:0]  c_mr;
  logic [MS_W-1:0]  c_ms;
  logic [MB_W-1:0]  c_mb;

  logic [DW-1:0]    lim_reg, lim_sm, div_a, div_b, div_q;
  logic             div_go, div_done, err_r;
  logic [MB_W-1:0]  blocks_r, blocks_min;
  logic [OW-1:0]    occ_r;
  logic [TPB_W:0]   tpb_up;
  logic [WPB_W-1:0] wpb;
  logic [MW_W-1:0]  maxw;
  logic [PROD_W-1:0] prod;
  logic [ACT_W-1:0] act;

  assign tpb_up = {1'b0, c_tpb} + (TPB_W+1)'(31);
  assign wpb    = WPB_W'(tpb_up >> 5);
  assign maxw   = MW_W'(c_mt >> 5);
  assign prod   = PROD_W'(c_rpt) * PROD_W'(c_tpb);
  assign act    = ACT_W'(blocks_r) * ACT_W'(wpb);

  occ_divider #(.DW(DW)) u_div (
    .clk(clk), .rst(rst), .go_i(div_go), .num_i(div_a), .den_i(div_b),
    .quo_o(div_q), .done_o(div_done)
  );

  occ_limit_min #(.MB_W(MB_W), .DW(DW)) u_min (
    .ceil_i(c_mb), .lim_a_i(lim_reg), .lim_b_i(lim_sm), .min_o(blocks_min)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
      {c_tpb, c_rpt, c_smb, c_mt, c_mr, c_ms, c_mb} <= '0;
      lim_reg <= '0; lim_sm <= '0; div_a <= '0; div_b <= '0;
      div_go <= 1'b0; err_r <= 1'b0; blocks_r <= '0; occ_r <= '0;
      blocks_o <= '0; act_warps_o <= '0; max_warps_o <= '0;
      occ_o <= '0; err_o <= 1'b0; done_o <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done_o <= 1'b0;
      case (st)
        ST_IDLE: if (start_i) begin
          c_tpb <= thr_per_blk_i;  c_rpt <= reg_per_thr_i;
          c_smb <= smem_per_blk_i; c_mt  <= sm_max_thr_i;
          c_mr  <= sm_max_reg_i;   c_ms  <= sm_max_smem_i;
          c_mb  <= sm_max_blk_i;
          st    <= ST_REG;
        end
        ST_REG: if (prod == '0) begin
          lim_reg <= DW'(c_mb);
          st      <= ST_SMEM;
        end else begin
          div_a <= DW'(c_mr); div_b <= DW'(prod); div_go <= 1'b1;
          st    <= ST_REG_W;
        end
        ST_REG_W: if (div_done) begin
          lim_reg <= div_q;
          st      <= ST_SMEM;
        end
        ST_SMEM: if (c_smb == '0) begin
          lim_sm <= DW'(c_mb);
          st     <= ST_MIN;
        end else begin
          div_a <= DW'(c_ms); div_b <= DW'(c_smb); div_go <= 1'b1;
          st    <= ST_SMEM_W;
        end
        ST_SMEM_W: if (div_done) begin
          lim_sm <= div_q;
          st     <= ST_MIN;
        end
        ST_MIN: begin
          blocks_r <= blocks_min;
          st       <= ST_OCC;
        end
        ST_OCC: if (maxw == '0) begin
          err_r <= 1'b1; occ_r <= '0; st <= ST_FIN;
        end else if (DW'(act) >= DW'(maxw)) begin
          err_r <= 1'b0; occ_r <= ONE; st <= ST_FIN;
        end else begin
          err_r <= 1'b0;
          div_a <= DW'(act) << OCC_FRAC; div_b <= DW'(maxw); div_go <= 1'b1;
          st    <= ST_OCC_W;
        end
        ST_OCC_W: if (div_done) begin
          occ_r <= div_q[OW-1:0];
          st    <= ST_FIN;
        end
        ST_FIN: begin
          blocks_o    <= blocks_r;
          act_warps_o <= act;
          max_warps_o <= maxw;
          occ_o       <= occ_r;
          err_o       <= err_r;
          done_o      <= 1'b1;
          st          <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // R2
  div_floor_chk: assert property (@(posedge clk) disable iff (rst)
    div_done |-> (DW2'(div_q) * DW2'(div_b) <= DW2'(div_a)) &&
                 ((DW2'(div_q) + DW2'(1)) * DW2'(div_b) > DW2'(div_a)));
  // R6
  occ_le_one_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> occ_o <= ONE);
  // R5
  blocks_cap_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> blocks_o <= c_mb);
  // R7
  err_zero_occ_chk: assert property (@(posedge clk) disable iff (rst)
    (done_o && err_o) |-> occ_o == '0);
  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);
  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st != ST_IDLE) |=> $stable(c_tpb) && $stable(c_mr) && $stable(c_smb) && $stable(c_mb));
  // R8
  out_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(occ_o) && $stable(blocks_o));
endmodule

// File: tb/sm_occupancy_calc_test.sv
`timescale 1ns/1ps
module sm_occupancy_calc_test;
  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [10:0] tpb; logic [7:0] rpt; logic [17:0] smb;
  logic [11:0] mt;  logic [16:0] mr; logic [17:0] ms; logic [5:0] mb;
  logic [5:0] blocks; logic [12:0] act; logic [6:0] maxw; logic [15:0] occ;
  logic err, done;
  int checks = 0, fails = 0, ndone = 0, cyc = 0;

  always #2.5 clk = ~clk;

  sm_occupancy_calc uut (
    .clk(clk), .rst(rst), .start_i(start),
    .thr_per_blk_i(tpb), .reg_per_thr_i(rpt), .smem_per_blk_i(smb),
    .sm_max_thr_i(mt), .sm_max_reg_i(mr), .sm_max_smem_i(ms), .sm_max_blk_i(mb),
    .blocks_o(blocks), .act_warps_o(act), .max_warps_o(maxw), .occ_o(occ),
    .err_o(err), .done_o(done)
  );

  always @(posedge clk) begin
    cyc++;
    if (done) ndone++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: run did not finish (actual %0d cycles, expected fewer)", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input longint a, input longint e);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, a, e);
    end
  endtask

  task automatic model(input longint t, r, s, xt, xr, xs, xb,
                       output longint eb, ea, emw, eo, output bit ee);
    longint wpb, pr, lr, ls;
    wpb = (t + 31) / 32;
    emw = xt / 32;
    pr  = r * t;
    lr  = (pr == 0) ? xb : xr / pr;
    ls  = (s == 0) ? xb : xs / s;
    eb  = xb;
    if (lr < eb) eb = lr;
    if (ls < eb) eb = ls;
    ea  = eb * wpb;
    ee  = (emw == 0);
    if (ee) eo = 0;
    else if (ea >= emw) eo = 32768;
    else eo = (ea * 32768) / emw;
  endtask

  task automatic drive(input longint t, r, s, xt, xr, xs, xb);
    tpb = 11'(t); rpt = 8'(r); smb = 18'(s);
    mt = 12'(xt); mr = 17'(xr); ms = 18'(xs); mb = 6'(xb);
  endtask

  task automatic wait_done();
    while (!done) @(negedge clk);
  endtask

  task automatic compare(input longint t, r, s, xt, xr, xs, xb, input string breq);
    longint eb, ea, emw, eo; bit ee;
    model(t, r, s, xt, xr, xs, xb, eb, ea, emw, eo, ee);
    chk(longint'(blocks) == eb, breq, blocks, eb);
    chk(longint'(act) == ea, "R5 active warps (R1 rounding)", act, ea);
    chk(longint'(maxw) == emw, "R1 max warps", maxw, emw);
    chk(longint'(occ) == eo, "R6 occupancy", occ, eo);
    chk(err == ee, "R7 error flag", err, ee);
  endtask

  task automatic run_case(input longint t, r, s, xt, xr, xs, xb, input string breq);
    @(negedge clk);
    drive(t, r, s, xt, xr, xs, xb);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    drive(0, 0, 0, 0, 0, 0, 0); // R8: inputs after the start cycle must not matter
    wait_done();
    compare(t, r, s, xt, xr, xs, xb, breq);
  endtask

  initial begin
    int seed;
    int d0;
    seed = $urandom(1234);
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    chk(blocks == 0 && act == 0 && maxw == 0 && occ == 0 && !err && !done,
        "R10 reset outputs", {blocks, act, occ}, 0);

    run_case(256, 32, 0, 2048, 65536, 102400, 32, "R2 register bound");     // exactly 1.0
    run_case(33, 20, 1000, 2048, 65536, 49152, 16, "R1 round-up 33 threads");
    run_case(128, 0, 40000, 2048, 65536, 100000, 16, "R3 shared-memory bound, R4 reg guard");
    run_case(128, 255, 0, 1536, 1000, 0, 8, "R2 register bound zero blocks");
    run_case(64, 0, 0, 2048, 65536, 65536, 5, "R4 both guards use ceiling");
    run_case(0, 40, 100, 2048, 65536, 65536, 9, "R4 zero threads guard");
    run_case(96, 16, 0, 0, 65536, 65536, 4, "R7 zero thread ceiling");
    run_case(96, 16, 0, 20, 65536, 65536, 4, "R7 sub-32 thread ceiling");
    run_case(1024, 0, 0, 1024, 65536, 65536, 4, "R6 clamp above one");
    run_case(96, 10, 12000, 2016, 65536, 49152, 3, "R5 ceiling bound fraction");

    // R9 start while busy
    @(negedge clk);
    drive(256, 32, 8000, 2048, 65536, 65536, 12);
    start = 1'b1; @(negedge clk); start = 1'b0;
    d0 = ndone;
    repeat (10) @(negedge clk);
    drive(32, 1, 0, 64, 100, 100, 1);
    start = 1'b1; @(negedge clk); start = 1'b0;
    wait_done();
    compare(256, 32, 8000, 2048, 65536, 65536, 12, "R9 result of first start");
    repeat (150) @(negedge clk);
    chk(ndone - d0 == 1, "R9 single done for overlapped start", ndone - d0, 1);
    compare(256, 32, 8000, 2048, 65536, 65536, 12, "R8 outputs held after done");

    for (int i = 0; i < 160; i++) begin
      longint t, r, s, xt, xr, xs, xb;
      t  = $urandom % 2048;
      r  = ($urandom % 4 == 0) ? 0 : $urandom % 256;
      s  = ($urandom % 4 == 0) ? 0 : $urandom % 65536;
      xt = $urandom % 4096;
      xr = $urandom % 131072;
      xs = $urandom % 262144;
      xb = $urandom % 64;
      run_case(t, r, s, xt, xr, xs, xb, "R5 random blocks (R2 R3 R4)");
    end

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule